// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register core of a general-purpose I/O controller. It owns a parameterised number of pins grouped into banks of 32. For each pin it holds a direction bit, an output latch bit and a filter-bypass bit. It also produces a conditioned copy of the pin input. The conditioned copy comes from a two-flop synchroniser, followed either by a three-sample majority filter or by the raw synchronised value, as the pin's bypass bit selects.

Software reaches the block over a plain 32-bit register bus made of address, write enable, write data and registered read data. Every register kind has its own base offset, and bank `n` of that kind sits at the base plus `4*n`. The output latch cannot be written directly. Bits are raised through a set register and lowered through a clear register, so a single write changes selected pins without a read-modify-write sequence. The latch drives the pin outputs and the direction bits drive the output enables.

Top module: `gpio_bank_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the following are all zero after that edge: every direction bit (`pin_oe`), every output latch bit (`pin_o`), every bypass bit and `bus_rdata`.
- R2: A write to the set register of bank n (offset 0x034 + 4n) sets output latch bit 32n+i for each bit i written as 1 and leaves bits written as 0 unchanged. The change is visible on `pin_o` after that edge.
- R3: A write to the clear register of bank n (offset 0x04C + 4n) clears output latch bit 32n+i for each bit i written as 1 and leaves bits written as 0 unchanged.
- R4: The direction register of bank n (offset 0x01C + 4n) is read/write. A bit of 1 makes the pin an output and drives `pin_oe` high; a bit of 0 makes it an input. Without a bus write, `pin_o` and `pin_oe` do not change.
- R5: Pin p belongs to bank p/32 at bit p%32 in every register kind, and a write to one bank leaves the other banks unchanged.
- R6: The level register of bank n (offset 0x004 + 4n) is read-only. For a pin whose bypass bit is 0, its bit is the majority of three consecutive synchronised samples, so a pin high for only one sample never reads as 1.
- R7: The bypass register of bank n (offset 0x094 + 4n) is read/write. For a pin whose bypass bit is 1, the level bit is the two-flop synchroniser output directly, so a one-sample pulse reaches the level register.
- R8: The set and clear registers read as zero. Addresses that are not word aligned, and addresses outside every register range, read as zero.
- R9: `bus_rdata` is registered: it shows the register selected by `bus_addr` at one edge after that edge. With the bypass bit set, a pin value sampled at edge e shows in `bus_rdata` after edge e+3; with the bypass bit clear, the majority of the samples from edges e-2, e-1 and e shows after edge e+4.
- R10: Register bits for pin numbers at or above `NUM_PINS` in the last bank read as zero and cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| pin_o | output | NUM_PINS | Output latch value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = pin is an output) |

## Verification
A corrupted latch, direction or bypass bit shows on `pin_o` or `pin_oe` at the next edge, or in `bus_rdata` one cycle after that bank is addressed. The reference model therefore compares all three every cycle against its own view of the latch, direction, bypass and level. A wrong filter or synchroniser depth appears as a level read that is one or more cycles early or late against the sample history the model keeps. The one-sample pulse test separates the filtered path from the bypassed path. Bank-select or bit-position errors appear when a write to one bank moves pins of the other bank, or when the bits above the last pin read as nonzero.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Base byte offsets of each register kind; banks follow at +4 per bank.
  localparam int OFS_LEVEL = 'h004;
  localparam int OFS_DIR   = 'h01C;
  localparam int OFS_SET   = 'h034;
  localparam int OFS_CLR   = 'h04C;
  localparam int OFS_BYP   = 'h094;
  // Kind spacing is 0x18, so at most six banks fit without overlap.
  localparam int MAX_BANKS = 6;

  typedef enum logic [2:0] {
    K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_BYP
  } reg_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BANK_W-1:0] bank
);
  localparam int SPAN = 4 * NUM_BANKS;

  int a;
  int off;

  always_comb begin
    a    = int'(addr);
    off  = 0;
    kind = K_NONE;
    if (addr[1:0] == 2'b00) begin
      if (a >= OFS_LEVEL && a < OFS_LEVEL + SPAN) begin
        kind = K_LEVEL; off = a - OFS_LEVEL;
      end else if (a >= OFS_DIR && a < OFS_DIR + SPAN) begin
        kind = K_DIR;   off = a - OFS_DIR;
      end else if (a >= OFS_SET && a < OFS_SET + SPAN) begin
        kind = K_SET;   off = a - OFS_SET;
      end else if (a >= OFS_CLR && a < OFS_CLR + SPAN) begin
        kind = K_CLR;   off = a - OFS_CLR;
      end else if (a >= OFS_BYP && a < OFS_BYP + SPAN) begin
        kind = K_BYP;   off = a - OFS_BYP;
      end
    end
    bank = BANK_W'(off >>> 2);
  end
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic bypass_i,
  output logic level_o
);
  logic       sync_a, sync_b;
  logic [2:0] hist;
  logic       vote;

  assign vote = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a  <= 1'b0;
      sync_b  <= 1'b0;
      hist    <= 3'b000;
      level_o <= 1'b0;
    end else begin
      sync_a  <= pin_i;
      sync_b  <= sync_a;
      hist    <= {hist[1:0], sync_b};
      level_o <= bypass_i ? sync_b : vote;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 48,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int NUM_BANKS = (NUM_PINS + 31) / 32;
  localparam int PAD_W     = NUM_BANKS * 32;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NUM_PINS-1:0] dir_q, out_q, byp_q, level_w;
  reg_kind_e           kind;
  logic [BANK_W-1:0]   bank;
  logic [PAD_W-1:0]    dir_pad, byp_pad, lvl_pad;
  logic [31:0]         rd_next;

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) i_dec (
    .addr(bus_addr), .kind(kind), .bank(bank)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_in_filter i_filt (
      .clk(clk), .rst(rst), .pin_i(pin_i[p]),
      .bypass_i(byp_q[p]), .level_o(level_w[p])
    );
  end

  // Register writes: one bank per access, per-bit set/clear on the latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      byp_q <= '0;
    end else if (bus_we) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (p / 32 == int'(bank)) begin
          case (kind)
            K_DIR: dir_q[p] <= bus_wdata[p % 32];
            K_BYP: byp_q[p] <= bus_wdata[p % 32];
            K_SET: if (bus_wdata[p % 32]) out_q[p] <= 1'b1;
            K_CLR: if (bus_wdata[p % 32]) out_q[p] <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  assign dir_pad = PAD_W'(dir_q);
  assign byp_pad = PAD_W'(byp_q);
  assign lvl_pad = PAD_W'(level_w);

  always_comb begin
    case (kind)
      K_LEVEL: rd_next = lvl_pad[int'(bank)*32 +: 32];
      K_DIR:   rd_next = dir_pad[int'(bank)*32 +: 32];
      K_BYP:   rd_next = byp_pad[int'(bank)*32 +: 32];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign pin_o  = out_q;
  assign pin_oe = dir_q;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 48,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe
);
  localparam int PAD_W = ((NUM_PINS + 31) / 32) * 32;
  localparam logic [31:0] B0MASK = (NUM_PINS >= 32) ? 32'hFFFF_FFFF
                                                     : 32'((64'd1 << NUM_PINS) - 64'd1);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(OFS_CLR);

  logic [PAD_W-1:0] o_pad;
  logic             unused_in;
  assign o_pad     = PAD_W'(pin_o);
  assign unused_in = ^pin_i;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pin_o == '0 && pin_oe == '0 && bus_rdata == '0)); // R1

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SET0) |=>
      (o_pad[31:0] == (($past(o_pad[31:0]) | $past(bus_wdata)) & B0MASK))); // R2

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CLR0) |=>
      (o_pad[31:0] == ($past(o_pad[31:0]) & ~$past(bus_wdata)))); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(pin_o) && $stable(pin_oe))); // R4

  AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_SET0 || bus_addr == A_CLR0 || bus_addr == '0) |=>
      (bus_rdata == '0)); // R8
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
  .pin_o(pin_o), .pin_oe(pin_oe)
);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  localparam int NP = 48;
  localparam int AW = 12;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o, pin_oe;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  gpio_bank_regs #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_bank_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // ---------------- behavioural reference model ----------------
  logic [NP-1:0] m_dir, m_out, m_byp, m_lvl;
  logic [31:0]   m_rd;
  logic [NP-1:0] hist[$];

  function automatic logic [NP-1:0] vote3(logic [NP-1:0] a, logic [NP-1:0] b,
                                          logic [NP-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // kind: 1 level, 2 dir, 3 set, 4 clr, 5 bypass, 0 none
  function automatic int kind_of(logic [AW-1:0] ad, output int bank);
    int a = int'(ad);
    int bases[5] = '{'h004, 'h01C, 'h034, 'h04C, 'h094};
    bank = 0;
    if (ad[1:0] != 2'b00) return 0;
    for (int k = 0; k < 5; k++)
      if (a >= bases[k] && a < bases[k] + 4*NB) begin
        bank = (a - bases[k]) / 4;
        return k + 1;
      end
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(logic [AW-1:0] ad);
    int b;
    int k = kind_of(ad, b);
    logic [63:0] v;
    case (k)
      1: v = 64'(m_lvl);
      2: v = 64'(m_dir);
      5: v = 64'(m_byp);
      default: v = '0;
    endcase
    return v[b*32 +: 32];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dir = '0; m_out = '0; m_byp = '0; m_lvl = '0; m_rd = '0;
      hist = {};
      for (int i = 0; i < 6; i++) hist.push_back('0);
    end else begin
      int b;
      int k;
      m_rd = exp_read(bus_addr);
      hist.push_front(pin_i);
      void'(hist.pop_back());
      m_lvl = (m_byp & hist[2]) | (~m_byp & vote3(hist[3], hist[4], hist[5]));
      if (bus_we) begin
        k = kind_of(bus_addr, b);
        for (int p = 0; p < NP; p++)
          if (p / 32 == b) begin
            if (k == 2) m_dir[p] = bus_wdata[p % 32];
            if (k == 5) m_byp[p] = bus_wdata[p % 32];
            if (k == 3 && bus_wdata[p % 32]) m_out[p] = 1'b1;
            if (k == 4 && bus_wdata[p % 32]) m_out[p] = 1'b0;
          end
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (model_on && !rst) begin
      checks += 3;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL R9 R6 R7 R8 rdata act=%h exp=%h", bus_rdata, m_rd);
      end
      if (pin_o !== m_out) begin
        errors++;
        $display("FAIL R2 R3 pin_o act=%h exp=%h", pin_o, m_out);
      end
      if (pin_oe !== m_dir) begin
        errors++;
        $display("FAIL R4 pin_oe act=%h exp=%h", pin_oe, m_dir);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Pulse pin 0 for one sample while reading level bank 0; report any 1 seen.
  task automatic pulse_seen(output bit seen);
    seen = 1'b0;
    @(negedge clk);
    bus_addr = 12'h004;
    repeat (8) @(negedge clk);
    pin_i[0] = 1'b1;
    @(negedge clk);
    pin_i[0] = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (bus_rdata[0]) seen = 1'b1;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    bit seen;
    repeat (5) @(negedge clk);
    chk("R1 pin_o after reset", 64'(pin_o), 64'd0);
    chk("R1 pin_oe after reset", 64'(pin_oe), 64'd0);
    chk("R1 rdata after reset", 64'(bus_rdata), 64'd0);
    rst = 1'b0;
    model_on = 1'b1;
    rd(12'h094, d); chk("R1 bypass reset value", 64'(d), 64'd0);

    // Set/clear on bank 0 and bank 1
    wr(12'h034, 32'hA5A5_00F0);
    chk("R2 set bank0", 64'(pin_o), 64'h0000_A5A5_00F0);
    wr(12'h034, 32'h0000_0001);
    chk("R2 set keeps zeros-written bits", 64'(pin_o), 64'h0000_A5A5_00F1);
    wr(12'h04C, 32'h0000_00F0);
    chk("R3 clear bank0", 64'(pin_o), 64'h0000_A5A5_0001);
    wr(12'h038, 32'hFFFF_1234);
    chk("R5 set bank1 leaves bank0", 64'(pin_o), 64'h1234_A5A5_0001);
    chk("R10 upper bits not set", 64'(pin_o) >> NP, 64'd0);
    wr(12'h050, 32'h0000_0204);
    chk("R3 clear bank1", 64'(pin_o), 64'h1030_A5A5_0001);

    // Direction
    wr(12'h01C, 32'h0F0F_0F0F);
    wr(12'h020, 32'hFFFF_FFFF);
    chk("R4 pin_oe after dir writes", 64'(pin_oe), 64'hFFFF_0F0F_0F0F);
    rd(12'h020, d); chk("R10 dir bank1 upper bits read zero", 64'(d), 64'h0000_FFFF);
    rd(12'h01C, d); chk("R4 dir bank0 readback", 64'(d), 64'h0F0F_0F0F);

    // Write-only / unmapped / misaligned reads
    rd(12'h034, d); chk("R8 set reads zero", 64'(d), 64'd0);
    rd(12'h04C, d); chk("R8 clear reads zero", 64'(d), 64'd0);
    rd(12'h01E, d); chk("R8 misaligned reads zero", 64'(d), 64'd0);
    rd(12'h200, d); chk("R8 unmapped reads zero", 64'(d), 64'd0);
    rd(12'h024, d); chk("R8 past last bank reads zero", 64'(d), 64'd0);

    // Level with filter and with bypass
    pin_i = 48'hFFFF_8000_0002;
    repeat (8) @(negedge clk);
    rd(12'h008, d); chk("R10 level bank1 upper bits zero", 64'(d), 64'h0000_FFFF);
    rd(12'h004, d); chk("R6 steady level bank0", 64'(d), 64'h8000_0002);
    pin_i = '0;
    pulse_seen(seen); chk("R6 one-sample pulse filtered out", 64'(seen), 64'd0);
    wr(12'h094, 32'h0000_0001);
    pulse_seen(seen); chk("R7 one-sample pulse passes bypass", 64'(seen), 64'd1);
    rd(12'h094, d); chk("R7 bypass readback", 64'(d), 64'h1);

    // Mixed traffic; reference model checks every cycle (R9 timing)
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] addrs[12] = '{12'h004, 12'h008, 12'h01C, 12'h020, 12'h034,
                                   12'h038, 12'h04C, 12'h050, 12'h094, 12'h098,
                                   12'h0AC, 12'h006};
      @(negedge clk);
      pin_i     = {$urandom, $urandom};
      bus_addr  = addrs[$urandom % 12];
      bus_we    = ($urandom % 3) == 0;
      bus_wdata = $urandom;
    end
    @(negedge clk);
    bus_we = 1'b0;
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule